// File: doc/BRIEF.md
# Synchronized Periodic Request Strobe Generator

This block produces a one-clock request strobe at a fixed period. An interpolating channel uses the strobe to ask upstream logic for its next input sample. The period is four times a programmable count N when the channel takes complex samples, and twice N when it takes real samples. Out of reset the strobe free-runs at that period.

A selected sync can realign the strobe phase. The sync source is picked by a two-bit mode: never, the external sync pin, an auxiliary internal sync, or held on. Each time the selected sync is active, any pending strobe is dropped and a fixed-latency sequence restarts. The latency is eight clocks when the shift setting is even and seven when it is odd. Once the first strobe of that sequence has fired, the strobe repeats at the period. A new N is loaded only when a strobe fires, so a period that is already under way is never cut short or stretched.

Top module: `req_strobe_gen`

## Requirements
- R1: While rst_n is low, req_strobe is low. With no sync, req_strobe is high in the first cycle that follows the first rising clock edge after rst_n goes high, and it then repeats at the period.
- R2: The period in clocks is 4*N when real_mode=0 (complex samples) and 2*N when real_mode=1 (real samples).
- R3: With shift_odd=0 (even shift), if the selected sync is active in cycle 0, req_strobe is low in cycles 1 to 7 and high in cycle 8.
- R4: With shift_odd=1 (odd shift), if the selected sync is active in cycle 0, req_strobe is low in cycles 1 to 6 and high in cycle 7.
- R5: req_strobe is never high for two cycles in a row. A sync that arrives while a strobe is pending cancels it, so req_strobe is low in the cycle after any active sync.
- R6: sync_mode selects the sync source. 0 means never active. 1 means the external pin sync_a_n, which is active low. 2 means sync_aux, which is active high. 3 means always active, and no strobe fires while mode 3 is held. The first strobe comes at the R3/R4 latency, counted from the last cycle of mode 3.
- R7: The period is taken from period_n and real_mode at the moment a strobe fires. A change made after a strobe applies from the interval that begins at the next strobe.
- R8: period_n=0 is treated as N=1.
- R9: In mode 0, a pulse on sync_a_n has no effect on req_strobe. In mode 1, a pulse on sync_aux has no effect on req_strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| period_n | input | N_W | Period count N (0 is treated as 1) |
| real_mode | input | 1 | 1 selects real samples (period 2N), 0 selects complex samples (period 4N) |
| shift_odd | input | 1 | Parity of the shift setting; 1 selects odd (latency 7) |
| sync_mode | input | 2 | Sync source select: 0 never, 1 external pin, 2 auxiliary, 3 always |
| sync_a_n | input | 1 | External sync, active low |
| sync_aux | input | 1 | Auxiliary internal sync, active high |
| req_strobe | output | 1 | One-clock sample request strobe |

## Verification
The strobe train is checked cycle by cycle after a reset release and after syncs. The tests cover even and odd shift parity and both sample modes, so a wrong latency, a wrong period multiplier and a swapped parity each show up at a different cycle. A sync issued one cycle before a strobe was due checks that the pending strobe is cancelled, not merged with the new one. An N change made just after a strobe separates a reload at the wrap from an immediate reload. Off-source pulses in modes 0 and 1, holding mode 3, and N=0 check the source mux and the period floor.

// File: rtl/strobe_pkg.sv
package strobe_pkg;
   typedef enum logic [1:0] {
      SYNC_NEVER = 2'd0,
      SYNC_EXT_A = 2'd1,
      SYNC_AUX   = 2'd2,
      SYNC_HOLD  = 2'd3
   } sync_mode_e;
endpackage

// File: rtl/strobe_sync_select.sv
module strobe_sync_select #(
   parameter bit SYNC_A_ACTIVE_LOW = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] mode,
   input  logic       sync_a_pin,
   input  logic       sync_aux,
   output logic       sync_sel
);
   import strobe_pkg::*;

   logic a_act;

   generate
      if (SYNC_A_ACTIVE_LOW) begin : g_a_low
         assign a_act = ~sync_a_pin;
      end else begin : g_a_high
         assign a_act = sync_a_pin;
      end
   endgenerate

   always_comb begin
      case (sync_mode_e'(mode))
         SYNC_NEVER: sync_sel = 1'b0;
         SYNC_EXT_A: sync_sel = a_act;
         SYNC_AUX:   sync_sel = sync_aux;
         default:    sync_sel = 1'b1;
      endcase
   end

   // R6: holding mode 3 must keep the sync asserted
   a_r6_hold_active: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd3) |-> sync_sel);
   // R9: mode 0 never passes any sync through
   a_r9_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd0) |-> !sync_sel);
endmodule

// File: rtl/strobe_period_calc.sv
module strobe_period_calc #(
   parameter int N_W = 10,
   parameter int P_W = N_W + 2
) (
   input  logic [N_W-1:0] period_n,
   input  logic           real_mode,
   output logic [P_W-1:0] period
);
   generate
      if (P_W < N_W + 2) begin : g_bad_width
         $error("strobe_period_calc: P_W must be at least N_W+2");
      end
   endgenerate

   logic [N_W-1:0] n_eff;

   always_comb begin
      n_eff = (period_n == '0) ? N_W'(1) : period_n;
      if (real_mode)
         period = P_W'({n_eff, 1'b0});
      else
         period = P_W'({n_eff, 2'b00});
   end
endmodule

// File: rtl/strobe_counter.sv
module strobe_counter #(
   parameter int P_W      = 12,
   parameter int CNT_W    = 12,
   parameter int LAT_EVEN = 8,
   parameter int LAT_ODD  = 7
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           sync,
   input  logic           shift_odd,
   input  logic [P_W-1:0] period,
   output logic           strobe
);
   generate
      if (LAT_EVEN < 2 || LAT_ODD < 2) begin : g_bad_lat
         $error("strobe_counter: latencies must be at least 2");
      end
      if (CNT_W < P_W) begin : g_bad_cnt
         $error("strobe_counter: CNT_W must cover the period");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] lat_m1;
   logic [CNT_W-1:0] period_zx;

   assign lat_m1    = shift_odd ? CNT_W'(LAT_ODD - 1) : CNT_W'(LAT_EVEN - 1);
   assign period_zx = CNT_W'(period);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= CNT_W'(1);
         strobe <= 1'b0;
      end else if (sync) begin
         cnt    <= lat_m1;
         strobe <= 1'b0;
      end else if (cnt == CNT_W'(1)) begin
         cnt    <= period_zx;
         strobe <= 1'b1;
      end else begin
         cnt    <= cnt - CNT_W'(1);
         strobe <= 1'b0;
      end
   end

   // R5: strobe is one clock wide
   a_r5_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |=> !strobe);
   // R5: a sync suppresses any strobe in the following cycle
   a_r5_sync_clears: assert property (@(posedge clk) disable iff (!rst_n)
      sync |=> !strobe);
   // R7: each strobe reloads the counter with the period present at that edge
   a_r7_reload: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |-> (cnt == $past(period_zx)));
   // R2: the counter never reaches zero, so the period never stalls
   a_r2_count_live: assert property (@(posedge clk) disable iff (!rst_n)
      cnt != '0);
endmodule

// File: rtl/req_strobe_gen.sv
module req_strobe_gen #(
   parameter int N_W               = 10,
   parameter int LAT_EVEN          = 8,
   parameter int LAT_ODD           = 7,
   parameter bit SYNC_A_ACTIVE_LOW = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [N_W-1:0] period_n,
   input  logic           real_mode,
   input  logic           shift_odd,
   input  logic [1:0]     sync_mode,
   input  logic           sync_a_n,
   input  logic           sync_aux,
   output logic           req_strobe
);
   localparam int P_W     = N_W + 2;
   localparam int LAT_MAX = (LAT_EVEN > LAT_ODD) ? LAT_EVEN : LAT_ODD;
   localparam int LAT_W   = $clog2(LAT_MAX + 1);
   localparam int CNT_W   = (P_W > LAT_W) ? P_W : LAT_W;

   generate
      if (N_W < 1) begin : g_bad_nw
         $error("req_strobe_gen: N_W must be at least 1");
      end
   endgenerate

   logic           sync_w;
   logic [P_W-1:0] period_w;

   strobe_sync_select #(
      .SYNC_A_ACTIVE_LOW(SYNC_A_ACTIVE_LOW)
   ) u_sel (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode      (sync_mode),
      .sync_a_pin(sync_a_n),
      .sync_aux  (sync_aux),
      .sync_sel  (sync_w)
   );

   strobe_period_calc #(
      .N_W(N_W),
      .P_W(P_W)
   ) u_per (
      .period_n (period_n),
      .real_mode(real_mode),
      .period   (period_w)
   );

   strobe_counter #(
      .P_W     (P_W),
      .CNT_W   (CNT_W),
      .LAT_EVEN(LAT_EVEN),
      .LAT_ODD (LAT_ODD)
   ) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .sync     (sync_w),
      .shift_odd(shift_odd),
      .period   (period_w),
      .strobe   (req_strobe)
   );

   // R8: the period is never below two clocks, even for N=0
   a_r8_min_period: assert property (@(posedge clk) disable iff (!rst_n)
      period_w >= P_W'(2));
   // R6: no strobe while mode 3 holds the sync
   a_r6_hold_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_mode == 2'd3) |=> !req_strobe);
endmodule

// File: tb/sim_req_strobe_gen.sv
module sim_req_strobe_gen;
   localparam int N_W = 10;

   logic           clk = 1'b0;
   logic           rst_n;
   logic [N_W-1:0] period_n;
   logic           real_mode;
   logic           shift_odd;
   logic [1:0]     sync_mode;
   logic           sync_a_n;
   logic           sync_aux;
   logic           req_strobe;

   int n_checks = 0;
   int n_fails  = 0;
   int cyc      = 0;

   always #10 clk = ~clk;

   req_strobe_gen #(.N_W(N_W)) u0 (
      .clk(clk), .rst_n(rst_n), .period_n(period_n), .real_mode(real_mode),
      .shift_odd(shift_odd), .sync_mode(sync_mode), .sync_a_n(sync_a_n),
      .sync_aux(sync_aux), .req_strobe(req_strobe)
   );

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: run hung, actual cycles=%0d expected<=20000", cyc);
         report();
      end
   end

   task automatic check(input logic act, input logic exp, input string tag, input int k);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s cycle %0d: req_strobe actual=%0b expected=%0b", tag, k, act, exp);
      end
   endtask

   // Samples req_strobe at negedges k=1..len after a cycle-0 event.
   task automatic watch(input int f, input int p1, input int p2, input int len,
                        input string tag, input int chg_at, input int new_n,
                        input int gl_at, input int gl_kind, input logic [1:0] rel_mode);
      for (int k = 1; k <= len; k++) begin
         logic exp;
         @(negedge clk);
         exp = (k == f) || (k == f + p1) || (k > f + p1 && ((k - f - p1) % p2) == 0);
         check(req_strobe, exp, tag, k);
         if (k == 1) begin
            sync_a_n = 1'b1; sync_aux = 1'b0; sync_mode = rel_mode;
         end
         if (k == chg_at) period_n = N_W'(new_n);
         if (gl_at != 0 && k == gl_at) begin
            if (gl_kind == 1) begin sync_mode = 2'd0; sync_a_n = 1'b0; end
            else sync_aux = 1'b1;
         end
         if (gl_at != 0 && k == gl_at + 1) begin
            sync_a_n = 1'b1; sync_aux = 1'b0; sync_mode = rel_mode;
         end
      end
   endtask

   task automatic pulse_a();
      @(negedge clk);
      sync_a_n = 1'b0;
   endtask

   task automatic t_reset();
      rst_n = 1'b0; period_n = 3; real_mode = 0; shift_odd = 0;
      sync_mode = 2'd1; sync_a_n = 1'b1; sync_aux = 1'b0;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         check(req_strobe, 1'b0, "R1 in reset", i);
      end
      rst_n = 1'b1;
      watch(1, 12, 12, 30, "R1 R2 free-run complex", 0, 0, 0, 0, 2'd1);
   endtask

   task automatic t_even_complex();
      period_n = 3; real_mode = 0; shift_odd = 0;
      pulse_a();
      watch(8, 12, 12, 40, "R3 R2 even complex", 0, 0, 0, 0, 2'd1);
   endtask

   task automatic t_odd_real();
      period_n = 5; real_mode = 1; shift_odd = 1;
      pulse_a();
      watch(7, 10, 10, 35, "R4 R2 odd real", 0, 0, 0, 0, 2'd1);
   endtask

   task automatic t_cancel();
      period_n = 3; real_mode = 0; shift_odd = 0;
      pulse_a();
      watch(8, 12, 12, 18, "R5 pre-cancel", 0, 0, 0, 0, 2'd1);
      pulse_a();
      watch(8, 12, 12, 30, "R5 cancel pending", 0, 0, 0, 0, 2'd1);
   endtask

   task automatic t_n_change();
      period_n = 2; real_mode = 0; shift_odd = 0;
      pulse_a();
      watch(8, 8, 16, 50, "R7 change at wrap", 8, 4, 0, 0, 2'd1);
   endtask

   task automatic t_mode_off();
      period_n = 3; real_mode = 0; shift_odd = 0;
      pulse_a();
      watch(8, 12, 12, 40, "R9 mode0 ignores pin", 0, 0, 12, 1, 2'd1);
   endtask

   task automatic t_mode_aux();
      period_n = 4; real_mode = 1; shift_odd = 1;
      @(negedge clk);
      sync_mode = 2'd2; sync_aux = 1'b1;
      watch(7, 8, 8, 30, "R6 aux source", 0, 0, 0, 0, 2'd2);
      pulse_a();
      sync_mode = 2'd1;
      watch(7, 8, 8, 30, "R9 mode1 ignores aux", 0, 0, 10, 2, 2'd1);
   endtask

   task automatic t_mode_hold();
      period_n = 1; real_mode = 0; shift_odd = 0;
      @(negedge clk);
      sync_mode = 2'd3;
      watch(1000, 1, 1, 30, "R6 hold silent", 0, 0, 0, 0, 2'd3);
      @(negedge clk);
      watch(8, 4, 4, 20, "R6 release from hold", 0, 0, 0, 0, 2'd1);
   endtask

   task automatic t_n_zero();
      period_n = 0; real_mode = 0; shift_odd = 1;
      pulse_a();
      watch(7, 4, 4, 25, "R8 N=0 as N=1", 0, 0, 0, 0, 2'd1);
   endtask

   initial begin
      t_reset();
      t_even_complex();
      t_odd_real();
      t_cancel();
      t_n_change();
      t_mode_off();
      t_mode_aux();
      t_mode_hold();
      t_n_zero();
      report();
   end
endmodule